// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block keeps the per-line interrupt state for a group of CPUs. It stores an enable bit, a pending bit, a trigger mode and a CPU target mask for each line, and holds these in registers on a simple 32-bit register bus. Lines come in banks of 32. Lines 0 to 31 are per-CPU lines with fixed configuration. Lines from 32 upward are shared lines that software can configure fully.

Each CPU gets one request output. The output rises when the global distributor enable is set and at least one line is pending, enabled and aimed at that CPU. Software enables and disables lines through separate set and clear words, so a single write changes only the chosen bits. Software clears latched edge events through a clear-pending word.

Byte addresses use `addr[11:2]` as the word index:

| Region | Byte address |
|---|---|
| control | 0x000 |
| identification | 0x004 |
| set-enable word w | 0x100+4w |
| clear-enable word w | 0x180+4w |
| clear-pending word w | 0x200+4w |
| trigger-config word c | 0x300+4c |
| target word t | 0x400+4t |

Top module: `irqd_regblock`

## Requirements
- R1: Writing a 1 to bit b of set-enable word w enables line 32w+b. A 0 bit leaves its line unchanged. Reading either the set-enable word or the clear-enable word returns the current enable bits. Enables reset to 0.
- R2: Writing a 1 to bit b of clear-enable word w disables line 32w+b. A 0 bit leaves its line unchanged.
- R3: Writing a 1 to bit b of clear-pending word w clears a latched edge event on line 32w+b. A 0 bit has no effect. A level line is not affected. Reading the word returns the current pending bits.
- R4: An edge-mode line becomes pending on a rising edge of its input and stays pending after the input falls. A level-mode line is pending exactly while its input is high.
- R5: The mode of line v sits in config word v>>4 at bit 2*(v&15)+1. A 1 selects edge mode and a 0 selects level mode. Shared lines reset to edge mode. Even bits read 0. Config words for lines 0 to 31 read 0 (level mode) and ignore writes.
- R6: The target mask of line v sits in target word v>>2, byte v&3, and bit k of the mask selects CPU k. Only the low NUM_CPUS bits are stored, and higher bits read 0. Shared lines reset to 0x01. Lines 0 to 31 read all present CPUs and ignore writes.
- R7: The identification word reads bits [4:0] = NUM_WORDS-1 and bits [7:5] = NUM_CPUS-1. All other bits read 0.
- R8: Bit 0 of the control word is the global enable and resets to 0. While it is 0, every cpu_irq output is low.
- R9: cpu_irq[k] is registered. It reflects (enable && pending && target bit k for some line) as it stood one clock earlier.
- R10: rdata is loaded in the clock edge where rd_en is high, and holds its value otherwise. Unmapped addresses and words beyond the configured lines read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_in | input | 32*NUM_WORDS | Interrupt line inputs, synchronous to clk |
| cpu_irq | output | NUM_CPUS | Per-CPU request output |

## Verification
A wrong enable, pending or target bit shows up on cpu_irq two clocks after the line input or the register write that exposes it, once the global enable is set. The same bit is also visible on rdata one cycle after a read of its word. A latched edge event that fails to clear keeps cpu_irq high after the clear-pending write. A level line that wrongly latches keeps pending set after its input falls. Reading each region back through the bus after every write separates a storage fault from a routing fault.

// File: rtl/irqd_pkg.sv
// Package: shared constants and register region codes for the interrupt
// distributor register block. Assumes 32 lines per bank word.
package irqd_pkg;
    localparam int LINES_PER_WORD = 32;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_IDENT,
        RG_SETEN,
        RG_CLREN,
        RG_CLRPEND,
        RG_CFG,
        RG_TGT
    } irqd_region_e;
endpackage

// File: rtl/irqd_line_word.sv
// Module: irqd_line_word
// Holds enable, edge latch, trigger mode and target masks for one bank of
// 32 lines, and reports which CPUs this bank requests.
// Assumes: irq_in is synchronous to clk; write strobes are one-hot and
// already decoded for this bank. PRIVATE banks have fixed mode and targets.
module irqd_line_word #(
    parameter int NUM_CPUS = 2,
    parameter bit PRIVATE  = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [31:0]                irq_in,
    input  logic [31:0]                wdata,
    input  logic                       set_en_we,
    input  logic                       clr_en_we,
    input  logic                       clr_pend_we,
    input  logic [1:0]                 cfg_we,
    input  logic [7:0]                 tgt_we,
    output logic [31:0]                en_q,
    output logic [31:0]                pend,
    output logic [31:0]                edge_cfg,
    output logic [31:0][NUM_CPUS-1:0]  tgt,
    output logic [NUM_CPUS-1:0]        cpu_hit
);
    logic [31:0] prev_in;
    logic [31:0] edge_latch;
    logic [31:0] rise;
    logic [31:0] clr_mask;

    // Enable bits: write-one-to-set and write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_en_we) begin
            en_q <= en_q | wdata;
        end else if (clr_en_we) begin
            en_q <= en_q & ~wdata;
        end
    end

    // Previous input sample for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_in <= '0;
        else        prev_in <= irq_in;
    end

    assign rise     = irq_in & ~prev_in;
    assign clr_mask = clr_pend_we ? wdata : '0;

    // Edge latch: set by a rising edge, cleared by clear-pending, dropped in level mode
    always_ff @(posedge clk) begin
        if (!rst_n) edge_latch <= '0;
        else        edge_latch <= ((edge_latch & ~clr_mask) | rise) & edge_cfg;
    end

    // Pending view: latched event for edge lines, the raw input for level lines
    assign pend = (edge_cfg & edge_latch) | (~edge_cfg & irq_in);

    generate
        if (PRIVATE) begin : g_fixed
            // Fixed mode and targets for per-CPU lines
            always_comb begin
                edge_cfg = '0;
                for (int i = 0; i < 32; i++) tgt[i] = '1;
            end
        end else begin : g_prog
            logic [31:0]               cfg_q;
            logic [31:0][NUM_CPUS-1:0] tgt_q;

            // Trigger mode: odd bits of the two config words of this bank
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q <= '1;
                end else begin
                    for (int h = 0; h < 2; h++) begin
                        if (cfg_we[h]) begin
                            for (int k = 0; k < 16; k++) cfg_q[16*h+k] <= wdata[2*k+1];
                        end
                    end
                end
            end

            // Target masks: one byte lane per line, four lines per word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < 32; i++) tgt_q[i] <= NUM_CPUS'(1);
                end else begin
                    for (int s = 0; s < 8; s++) begin
                        if (tgt_we[s]) begin
                            for (int j = 0; j < 4; j++) tgt_q[4*s+j] <= wdata[8*j +: NUM_CPUS];
                        end
                    end
                end
            end

            assign edge_cfg = cfg_q;
            assign tgt      = tgt_q;
        end
    endgenerate

    // Per-CPU request of this bank
    always_comb begin
        cpu_hit = '0;
        for (int k = 0; k < NUM_CPUS; k++) begin
            for (int i = 0; i < 32; i++) begin
                cpu_hit[k] = cpu_hit[k] | (pend[i] & en_q[i] & tgt[i][k]);
            end
        end
    end

    AST_SET_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_we |=> ((en_q & $past(wdata)) == $past(wdata)));  // R1
    AST_CLR_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_we |=> ((en_q & $past(wdata)) == 32'h0));  // R2
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_pend_we && cfg_we == 2'b00) |=>
            (((pend & edge_cfg) & $past(pend & edge_cfg)) == $past(pend & edge_cfg)));  // R4
endmodule

// File: rtl/irqd_route.sv
// Module: irqd_route
// Merges the per-bank CPU requests and gates them with the global enable.
// It drives one registered request output per CPU.
// Assumes: hit_a is already the AND of pending, enable and target per line.
module irqd_route #(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 dist_en,
    input  logic [NUM_WORDS-1:0][NUM_CPUS-1:0]   hit_a,
    output logic [NUM_CPUS-1:0]                  cpu_irq
);
    logic [NUM_CPUS-1:0] any_hit;

    // OR the requests of all banks per CPU
    always_comb begin
        any_hit = '0;
        for (int w = 0; w < NUM_WORDS; w++) any_hit = any_hit | hit_a[w];
    end

    // Registered, globally gated request outputs
    always_ff @(posedge clk) begin
        if (!rst_n)       cpu_irq <= '0;
        else if (dist_en) cpu_irq <= any_hit;
        else              cpu_irq <= '0;
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dist_en |=> (cpu_irq == '0));  // R8
endmodule

// File: rtl/irqd_regblock.sv
// Module: irqd_regblock (top)
// Memory-mapped interrupt distributor state: global enable, identification,
// set/clear enable, clear-pending, trigger mode and CPU targets.
// Assumes: single-cycle wr_en/rd_en strobes, word-aligned byte addresses,
// NUM_WORDS in 1..32 and NUM_CPUS in 1..8. Bank 0 holds per-CPU lines.
module irqd_regblock #(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 2,
    localparam int NUM_LINES = NUM_WORDS * irqd_pkg::LINES_PER_WORD
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [11:0]           addr,
    input  logic [31:0]           wdata,
    input  logic                  wr_en,
    input  logic                  rd_en,
    output logic [31:0]           rdata,
    input  logic [NUM_LINES-1:0]  irq_in,
    output logic [NUM_CPUS-1:0]   cpu_irq
);
    import irqd_pkg::*;

    logic [9:0]   waddr;
    irqd_region_e region;
    logic [7:0]   idx;
    logic         ctrl_en;
    logic [31:0]  rd_val;

    logic [NUM_WORDS-1:0][31:0]                en_a;
    logic [NUM_WORDS-1:0][31:0]                pend_a;
    logic [NUM_WORDS-1:0][31:0]                cfg_a;
    logic [NUM_WORDS-1:0][31:0][NUM_CPUS-1:0]  tgt_a;
    logic [NUM_WORDS-1:0][NUM_CPUS-1:0]        hit_a;

    assign waddr = addr[11:2];

    // Address decode into region and word index
    always_comb begin
        region = RG_NONE;
        idx    = '0;
        if (waddr == 10'd0) begin
            region = RG_CTRL;
        end else if (waddr == 10'd1) begin
            region = RG_IDENT;
        end else if (waddr[9:5] == 5'h02) begin
            region = RG_SETEN;
            idx    = {3'b000, waddr[4:0]};
        end else if (waddr[9:5] == 5'h03) begin
            region = RG_CLREN;
            idx    = {3'b000, waddr[4:0]};
        end else if (waddr[9:5] == 5'h04) begin
            region = RG_CLRPEND;
            idx    = {3'b000, waddr[4:0]};
        end else if (waddr[9:6] == 4'h3) begin
            region = RG_CFG;
            idx    = {2'b00, waddr[5:0]};
        end else if (waddr[9:8] == 2'b01) begin
            region = RG_TGT;
            idx    = waddr[7:0];
        end
    end

    // Global distributor enable
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_en <= 1'b0;
        else if (wr_en && region == RG_CTRL) ctrl_en <= wdata[0];
    end

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_bank
            logic       set_en_we;
            logic       clr_en_we;
            logic       clr_pend_we;
            logic [1:0] cfg_we;
            logic [7:0] tgt_we;

            assign set_en_we   = wr_en && region == RG_SETEN   && idx == 8'(w);
            assign clr_en_we   = wr_en && region == RG_CLREN   && idx == 8'(w);
            assign clr_pend_we = wr_en && region == RG_CLRPEND && idx == 8'(w);
            for (genvar h = 0; h < 2; h++) begin : g_cfgwe
                assign cfg_we[h] = wr_en && region == RG_CFG && idx == 8'(2*w+h);
            end
            for (genvar s = 0; s < 8; s++) begin : g_tgtwe
                assign tgt_we[s] = wr_en && region == RG_TGT && idx == 8'(8*w+s);
            end

            irqd_line_word #(
                .NUM_CPUS (NUM_CPUS),
                .PRIVATE  (w == 0)
            ) i_word (
                .clk         (clk),
                .rst_n       (rst_n),
                .irq_in      (irq_in[32*w +: 32]),
                .wdata       (wdata),
                .set_en_we   (set_en_we),
                .clr_en_we   (clr_en_we),
                .clr_pend_we (clr_pend_we),
                .cfg_we      (cfg_we),
                .tgt_we      (tgt_we),
                .en_q        (en_a[w]),
                .pend        (pend_a[w]),
                .edge_cfg    (cfg_a[w]),
                .tgt         (tgt_a[w]),
                .cpu_hit     (hit_a[w])
            );
        end
    endgenerate

    irqd_route #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_CPUS  (NUM_CPUS)
    ) i_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .dist_en (ctrl_en),
        .hit_a   (hit_a),
        .cpu_irq (cpu_irq)
    );

    // Read data selection for the addressed word
    always_comb begin
        rd_val = '0;
        case (region)
            RG_CTRL:  rd_val[0] = ctrl_en;
            RG_IDENT: begin
                rd_val[4:0] = 5'(NUM_WORDS - 1);
                rd_val[7:5] = 3'(NUM_CPUS - 1);
            end
            RG_SETEN, RG_CLREN: begin
                for (int w = 0; w < NUM_WORDS; w++) if (idx == 8'(w)) rd_val = en_a[w];
            end
            RG_CLRPEND: begin
                for (int w = 0; w < NUM_WORDS; w++) if (idx == 8'(w)) rd_val = pend_a[w];
            end
            RG_CFG: begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    for (int h = 0; h < 2; h++) begin
                        if (idx == 8'(2*w+h)) begin
                            for (int k = 0; k < 16; k++) rd_val[2*k+1] = cfg_a[w][16*h+k];
                        end
                    end
                end
            end
            RG_TGT: begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    for (int s = 0; s < 8; s++) begin
                        if (idx == 8'(8*w+s)) begin
                            for (int j = 0; j < 4; j++) rd_val[8*j +: NUM_CPUS] = tgt_a[w][4*s+j];
                        end
                    end
                end
            end
            default: rd_val = '0;
        endcase
    end

    // Registered read data, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));  // R10
endmodule

// File: tb/test_irqd_regblock.sv
module test_irqd_regblock;
    localparam int NW = 2;
    localparam int NC = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [31:0]       rdata;
    logic [NW*32-1:0]  irq_in = '0;
    logic [NC-1:0]     cpu_irq;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    irqd_regblock #(.NUM_WORDS(NW), .NUM_CPUS(NC)) i_irqd_regblock (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .irq_in(irq_in), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R8 reset cpu_irq", 32'(cpu_irq), 32'h0);
        bus_rd(12'h000, d); check("R8 reset ctrl", d, 32'h0);
        bus_rd(12'h104, d); check("R1 reset enables", d, 32'h0);
        bus_rd(12'h300, d); check("R5 private cfg", d, 32'h0);
        bus_rd(12'h308, d); check("R5 reset cfg edge", d, 32'hAAAAAAAA);
        bus_rd(12'h420, d); check("R6 reset target", d, 32'h01010101);
        bus_rd(12'h400, d); check("R6 private target", d, 32'h03030303);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        bus_rd(12'h004, d); check("R7 ident", d, 32'h00000021);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_wr(12'h104, 32'h5);
        bus_rd(12'h104, d); check("R1 set-enable", d, 32'h5);
        bus_rd(12'h184, d); check("R1 read via clear word", d, 32'h5);
        bus_wr(12'h104, 32'h0);
        bus_rd(12'h104, d); check("R1 zero write no effect", d, 32'h5);
        bus_wr(12'h184, 32'h1);
        bus_rd(12'h104, d); check("R2 clear-enable", d, 32'h4);
        bus_wr(12'h184, 32'h0);
        bus_rd(12'h184, d); check("R2 zero write no effect", d, 32'h4);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        @(negedge clk); irq_in[34] = 1'b1;
        @(negedge clk); irq_in[34] = 1'b0;
        idle(1);
        bus_rd(12'h204, d); check("R4 edge latched after fall", d, 32'h4);
        bus_wr(12'h204, 32'h0);
        bus_rd(12'h204, d); check("R3 zero clear no effect", d, 32'h4);
        bus_wr(12'h204, 32'h4);
        bus_rd(12'h204, d); check("R3 clear-pending", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        bus_wr(12'h308, 32'hAAAAAA2A);
        bus_rd(12'h308, d); check("R5 cfg line 35 level", d, 32'hAAAAAA2A);
        bus_wr(12'h300, 32'hFFFFFFFF);
        bus_rd(12'h300, d); check("R5 private cfg ignores write", d, 32'h0);
        @(negedge clk); irq_in[35] = 1'b1;
        bus_rd(12'h204, d); check("R4 level pending", d, 32'h8);
        bus_wr(12'h204, 32'h8);
        bus_rd(12'h204, d); check("R3 level unaffected by clear", d, 32'h8);
        @(negedge clk); irq_in[35] = 1'b0;
        bus_rd(12'h204, d); check("R4 level drops", d, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        bus_wr(12'h000, 32'h1);
        @(negedge clk); irq_in[34] = 1'b1;
        @(negedge clk); irq_in[34] = 1'b0;
        idle(2);
        check("R9 routed to cpu0", 32'(cpu_irq), 32'h1);
        bus_wr(12'h420, 32'h00020101);
        idle(1);
        check("R6 retarget cpu1", 32'(cpu_irq), 32'h2);
        bus_rd(12'h420, d); check("R6 target readback", d, 32'h00020101);
        bus_wr(12'h420, 32'h00FF0101);
        bus_rd(12'h420, d); check("R6 upper target bits read 0", d, 32'h00030101);
        check("R9 both cpus", 32'(cpu_irq), 32'h3);
        bus_wr(12'h184, 32'h4);
        check("R9 one-cycle latency old", 32'(cpu_irq), 32'h3);
        @(negedge clk);
        check("R9 disabled line drops", 32'(cpu_irq), 32'h0);
        bus_wr(12'h104, 32'h4);
        check("R9 one-cycle latency new", 32'(cpu_irq), 32'h0);
        @(negedge clk);
        check("R9 re-enabled line", 32'(cpu_irq), 32'h3);
        bus_wr(12'h000, 32'h0);
        @(negedge clk);
        check("R8 global disable gates", 32'(cpu_irq), 32'h0);
        bus_wr(12'h204, 32'h4);
    endtask

    task automatic t_private();
        logic [31:0] d;
        bus_wr(12'h404, 32'h0);
        bus_rd(12'h404, d); check("R6 private target ignores write", d, 32'h03030303);
        bus_wr(12'h000, 32'h1);
        bus_wr(12'h100, 32'h20);
        @(negedge clk); irq_in[5] = 1'b1;
        idle(2);
        check("R9 private line to all cpus", 32'(cpu_irq), 32'h3);
        @(negedge clk); irq_in[5] = 1'b0;
        idle(2);
        check("R4 private level drops", 32'(cpu_irq), 32'h0);
        bus_wr(12'h000, 32'h0);
    endtask

    task automatic t_read();
        logic [31:0] d;
        bus_rd(12'h7F0, d); check("R10 beyond lines reads 0", d, 32'h0);
        bus_rd(12'h010, d); check("R10 unmapped reads 0", d, 32'h0);
        bus_rd(12'h004, d);
        @(negedge clk); addr = 12'h000;
        idle(3);
        check("R10 rdata holds", rdata, 32'h00000021);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_ident();
        t_enable();
        t_edge();
        t_level();
        t_route();
        t_private();
        t_read();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule